// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock

This block is a byte-wide, memory-mapped calendar clock. It keeps seconds, minutes, hours, day of week, date, month, year within the century and the century, each as one packed BCD byte. An external tick input is divided by a parameterised count, and the calendar moves forward one second each time that count is reached. Rollover follows the real month lengths, with a leap February in every year divisible by four.

Software reaches the clock through nine byte registers near the top of an address window of 2^ADDR_W bytes. A control byte has two bits. The freeze bit holds the values software sees, so a multi-byte read is consistent while the internal count keeps running. The load bit sends register writes into a holding bank without touching the live count. The new time goes into the counters when the load bit is cleared.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the clock reads 2000-01-01 00:00:00 with day of week 1, and the control byte reads 0x00.
- R2: With the top address T = 2^ADDR_W-1, the byte map is: T-7 control, T-6 seconds, T-5 minutes, T-4 hours, T-3 day of week, T-2 date, T-1 month, T year within century, T-14 century. Every time field is packed BCD with the tens digit in bits 7:4. With no bit set in the control byte, a read returns the live count.
- R3: The seconds field advances once for every TICK_DIV cycles in which `sec_tick` is high. Cycles without a tick leave the time unchanged.
- R4: Seconds and minutes wrap from 59 to 00 and carry. Hours run from 00 to 23 in 24-hour form and carry into the date on 23 to 00.
- R5: The day of week steps when the hour wraps from 23 to 00, and goes from 7 back to 1.
- R6: The date wraps to 01 after the last day of the month: 31 for months 1, 3, 5, 7, 8, 10 and 12, 30 for months 4, 6, 9 and 11, and for month 2 either 29 (year field divisible by 4) or 28.
- R7: The month wraps from 12 to 01 and increments the year. The year wraps from 99 to 00 and increments the century, and the century wraps from 99 to 00.
- R8: Control bit 6 (freeze) makes the time registers read the values the live count had in the cycle the bit was written. The live count keeps advancing meanwhile. Once the bit is cleared, reads return the live count again.
- R9: While control bit 7 (load) is set, writes to the time registers go into a holding bank that reads back as written. The live count keeps advancing on ticks.
- R10: A control write that clears bit 7 while it is set copies the holding bank into the live count and restarts the tick divider. A tick in that same cycle is discarded.
- R11: Writes to time registers while bit 7 is clear change nothing.
- R12: Addresses outside the map read 0x00 and ignore writes. Control bits 5:0 read 0 and ignore writes. `bus_rdata` is 0x00 while `bus_sel` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | Tick pulse; TICK_DIV pulses make one second |
| bus_sel | input | 1 | Register port select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | ADDR_W | Byte address within the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address and state |

## Verification
The collision that matters is a control write that commits the holding bank in the same cycle as the tick that would complete a second. The bench commits 23:59:59 with a tick in that cycle. It then checks that the seconds field still reads 59 after three more ticks and rolls over only on the fourth. That shows the commit took priority and the divider restarted from zero. A second overlap, a freeze write that coincides with a running count, is judged by comparing the held snapshot with a count taken before the freeze edge.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

   localparam int FRZ_BIT = 6;
   localparam int LDE_BIT = 7;

   typedef struct packed {
      logic [7:0] cent;
      logic [7:0] year;
      logic [7:0] month;
      logic [7:0] date;
      logic [7:0] dow;
      logic [7:0] hour;
      logic [7:0] min;
      logic [7:0] sec;
   } rtc_time_t;

   typedef enum logic [3:0] {
      FLD_NONE, FLD_CTRL, FLD_SEC, FLD_MIN, FLD_HOUR,
      FLD_DOW, FLD_DATE, FLD_MONTH, FLD_YEAR, FLD_CENT
   } rtc_field_e;

   localparam rtc_time_t RTC_RESET_TIME = '{
      cent: 8'h20, year: 8'h00, month: 8'h01, date: 8'h01,
      dow: 8'h01, hour: 8'h00, min: 8'h00, sec: 8'h00};

   // next packed-BCD value, decimal carry from ones into tens
   function automatic logic [7:0] bcd_step(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      else                return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // last valid date of a month; tens*10 mod 4 equals (tens mod 2)*2
   function automatic logic [7:0] month_last_day(input logic [7:0] mon,
                                                 input logic [7:0] yr);
      logic [1:0] rem4;
      rem4 = {yr[4], 1'b0} + yr[1:0];
      case (mon)
         8'h02: return (rem4 == 2'd0) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default: return 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic restart,
   output logic step
);
   if (DIV < 1) begin : g_bad_div
      $error("rtc_tick_div: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_direct
      assign step = tick & ~restart;
   end else begin : g_count
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt;

      assign step = tick && !restart && (cnt == LAST);

      always_ff @(posedge clk) begin
         if (!rst_n)        cnt <= '0;
         else if (restart)  cnt <= '0;
         else if (tick)     cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end

      // R10
      div_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
         restart |=> (cnt == '0));
      // R3
      div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!tick && !restart) |=> $stable(cnt));
   end
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
   import rtc_cal_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      step,
   input  logic      load,
   input  rtc_time_t load_val,
   output rtc_time_t now
);
   rtc_time_t nxt;
   logic sec_c, min_c, hr_c, day_c, mon_c, yr_c;

   always_comb begin
      nxt   = now;
      sec_c = (now.sec == 8'h59);
      min_c = sec_c && (now.min == 8'h59);
      hr_c  = min_c && (now.hour == 8'h23);
      day_c = hr_c  && (now.date == month_last_day(now.month, now.year));
      mon_c = day_c && (now.month == 8'h12);
      yr_c  = mon_c && (now.year == 8'h99);

      nxt.sec = sec_c ? 8'h00 : bcd_step(now.sec);
      if (sec_c) nxt.min  = min_c ? 8'h00 : bcd_step(now.min);
      if (min_c) nxt.hour = hr_c  ? 8'h00 : bcd_step(now.hour);
      if (hr_c) begin
         nxt.dow  = (now.dow == 8'h07) ? 8'h01 : bcd_step(now.dow);
         nxt.date = day_c ? 8'h01 : bcd_step(now.date);
      end
      if (day_c) nxt.month = mon_c ? 8'h01 : bcd_step(now.month);
      if (mon_c) nxt.year  = yr_c  ? 8'h00 : bcd_step(now.year);
      if (yr_c)  nxt.cent  = (now.cent == 8'h99) ? 8'h00 : bcd_step(now.cent);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     now <= RTC_RESET_TIME;
      else if (load)  now <= load_val;
      else if (step)  now <= nxt;
   end

   // R4
   sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && now.sec == 8'h59) |=> (now.sec == 8'h00));
   // R5
   dow_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && now.dow == 8'h07 && now.hour == 8'h23 &&
       now.min == 8'h59 && now.sec == 8'h59) |=> (now.dow == 8'h01));
   // R10
   load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (now == $past(load_val)));
endmodule

// File: rtl/rtc_addr_map.sv
module rtc_addr_map
   import rtc_cal_pkg::*;
#(
   parameter int ADDR_W = 15
) (
   input  logic [ADDR_W-1:0] addr,
   output rtc_field_e        fld
);
   localparam int unsigned TOP = (1 << ADDR_W) - 1;
   localparam logic [ADDR_W-1:0] CENT_ADDR = ADDR_W'(TOP - 14);

   always_comb begin
      fld = FLD_NONE;
      if (&addr[ADDR_W-1:3]) begin
         case (addr[2:0])
            3'd0: fld = FLD_CTRL;
            3'd1: fld = FLD_SEC;
            3'd2: fld = FLD_MIN;
            3'd3: fld = FLD_HOUR;
            3'd4: fld = FLD_DOW;
            3'd5: fld = FLD_DATE;
            3'd6: fld = FLD_MONTH;
            default: fld = FLD_YEAR;
         endcase
      end else if (addr == CENT_ADDR) begin
         fld = FLD_CENT;
      end
   end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
   import rtc_cal_pkg::*;
#(
   parameter int ADDR_W   = 15,
   parameter int TICK_DIV = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_tick,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata
);
   if (ADDR_W < 4 || ADDR_W > 24) begin : g_bad_addr
      $error("rtc_calendar: ADDR_W must lie in 4..24");
   end

   rtc_field_e fld;
   rtc_time_t  live, shadow, view;
   logic frz_q, lde_q, hold;
   logic ctrl_wr, commit, time_wr, step;

   rtc_addr_map #(.ADDR_W(ADDR_W)) u_map (.addr(bus_addr), .fld(fld));

   assign hold    = frz_q | lde_q;
   assign ctrl_wr = bus_sel && bus_wr && (fld == FLD_CTRL);
   assign commit  = ctrl_wr && lde_q && !bus_wdata[LDE_BIT];
   assign time_wr = bus_sel && bus_wr && lde_q &&
                    (fld != FLD_NONE) && (fld != FLD_CTRL);

   rtc_tick_div #(.DIV(TICK_DIV)) u_div (
      .clk(clk), .rst_n(rst_n), .tick(sec_tick), .restart(commit), .step(step));

   rtc_time_core u_core (
      .clk(clk), .rst_n(rst_n), .step(step), .load(commit),
      .load_val(shadow), .now(live));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frz_q <= 1'b0;
         lde_q <= 1'b0;
      end else if (ctrl_wr) begin
         frz_q <= bus_wdata[FRZ_BIT];
         lde_q <= bus_wdata[LDE_BIT];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) shadow <= RTC_RESET_TIME;
      else if (!hold) shadow <= live;
      else if (time_wr) begin
         case (fld)
            FLD_SEC:   shadow.sec   <= bus_wdata;
            FLD_MIN:   shadow.min   <= bus_wdata;
            FLD_HOUR:  shadow.hour  <= bus_wdata;
            FLD_DOW:   shadow.dow   <= bus_wdata;
            FLD_DATE:  shadow.date  <= bus_wdata;
            FLD_MONTH: shadow.month <= bus_wdata;
            FLD_YEAR:  shadow.year  <= bus_wdata;
            FLD_CENT:  shadow.cent  <= bus_wdata;
            default:   ;
         endcase
      end
   end

   assign view = hold ? shadow : live;

   always_comb begin
      bus_rdata = 8'h00;
      if (bus_sel) begin
         case (fld)
            FLD_CTRL:  bus_rdata = {lde_q, frz_q, 6'b0};
            FLD_SEC:   bus_rdata = view.sec;
            FLD_MIN:   bus_rdata = view.min;
            FLD_HOUR:  bus_rdata = view.hour;
            FLD_DOW:   bus_rdata = view.dow;
            FLD_DATE:  bus_rdata = view.date;
            FLD_MONTH: bus_rdata = view.month;
            FLD_YEAR:  bus_rdata = view.year;
            FLD_CENT:  bus_rdata = view.cent;
            default:   bus_rdata = 8'h00;
         endcase
      end
   end

   // R8
   freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frz_q && !lde_q) |=> $stable(shadow));
   // R9
   count_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lde_q && step) |=> (live != $past(live)));
   // R10
   commit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (live == $past(shadow)));
   // R11
   idle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && !lde_q && frz_q && fld != FLD_CTRL) |=> $stable(shadow));
endmodule

// File: tb/rtc_calendar_test.sv
module rtc_calendar_test;
   localparam int DIV = 4;
   localparam logic [14:0] A_CTRL = 15'h7FF8, A_SEC = 15'h7FF9, A_MIN = 15'h7FFA,
      A_HOUR = 15'h7FFB, A_DOW = 15'h7FFC, A_DATE = 15'h7FFD, A_MON = 15'h7FFE,
      A_YEAR = 15'h7FFF, A_CENT = 15'h7FF1;

   logic clk = 1'b0, rst_n = 1'b0, sec_tick = 1'b0;
   logic bus_sel = 1'b0, bus_wr = 1'b0;
   logic [14:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0, bus_rdata;

   int errors = 0, checks = 0, rot = 0;
   bit cmp_en = 1'b0, done = 1'b0;
   string cur_req = "R1";

   // reference model state (binary calendar plus BCD holding bank)
   int m_year, m_mon, m_date, m_dow, m_hour, m_min, m_sec, m_div;
   logic m_frz, m_lde;
   logic [7:0] m_sh [8];
   logic [7:0] old_b [8];
   logic [7:0] exp_rd;

   rtc_calendar #(.ADDR_W(15), .TICK_DIV(DIV)) uut (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_sel(bus_sel),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata));

   always #5 clk = ~clk;

   function automatic logic [7:0] to_bcd(input int v);
      return 8'(((v / 10) * 16) + (v % 10));
   endfunction
   function automatic int from_bcd(input logic [7:0] b);
      return int'(b[7:4]) * 10 + int'(b[3:0]);
   endfunction
   function automatic int days_of(input int mon, input int yr);
      if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
      return 31;
   endfunction
   function automatic int tidx(input logic [14:0] a);
      if (a == A_CENT) return 0;
      if (a >= A_SEC) return int'(a - A_CTRL);
      return -1;
   endfunction
   function automatic logic [7:0] live_byte(input int i);
      case (i)
         0: return to_bcd(m_year / 100);
         1: return to_bcd(m_sec);
         2: return to_bcd(m_min);
         3: return to_bcd(m_hour);
         4: return to_bcd(m_dow);
         5: return to_bcd(m_date);
         6: return to_bcd(m_mon);
         default: return to_bcd(m_year % 100);
      endcase
   endfunction
   function automatic logic [7:0] model_read();
      int ti;
      if (!bus_sel) return 8'h00;
      if (bus_addr == A_CTRL) return {m_lde, m_frz, 6'b0};
      ti = tidx(bus_addr);
      if (ti < 0) return 8'h00;
      return (m_frz || m_lde) ? m_sh[ti] : live_byte(ti);
   endfunction

   task automatic advance();
      m_sec++;
      if (m_sec == 60) begin
         m_sec = 0; m_min++;
         if (m_min == 60) begin
            m_min = 0; m_hour++;
            if (m_hour == 24) begin
               m_hour = 0;
               m_dow = (m_dow == 7) ? 1 : m_dow + 1;
               m_date++;
               if (m_date > days_of(m_mon, m_year)) begin
                  m_date = 1; m_mon++;
                  if (m_mon == 13) begin
                     m_mon = 1;
                     m_year = (m_year == 9999) ? 0 : m_year + 1;
                  end
               end
            end
         end
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_year = 2000; m_mon = 1; m_date = 1; m_dow = 1;
         m_hour = 0; m_min = 0; m_sec = 0; m_div = 0;
         m_frz = 1'b0; m_lde = 1'b0;
         for (int i = 0; i < 8; i++) m_sh[i] = live_byte(i);
      end else begin
         automatic bit is_w   = bus_sel && bus_wr;
         automatic bit ctrl_w = is_w && (bus_addr == A_CTRL);
         automatic bit commit = ctrl_w && m_lde && !bus_wdata[7];
         automatic int ti     = tidx(bus_addr);
         for (int i = 0; i < 8; i++) old_b[i] = live_byte(i);
         if (commit) begin
            m_year = from_bcd(m_sh[0]) * 100 + from_bcd(m_sh[7]);
            m_sec = from_bcd(m_sh[1]); m_min = from_bcd(m_sh[2]);
            m_hour = from_bcd(m_sh[3]); m_dow = from_bcd(m_sh[4]);
            m_date = from_bcd(m_sh[5]); m_mon = from_bcd(m_sh[6]);
            m_div = 0;
         end else if (sec_tick) begin
            if (m_div == DIV - 1) begin m_div = 0; advance(); end
            else m_div++;
         end
         if (!(m_frz || m_lde)) begin
            for (int i = 0; i < 8; i++) m_sh[i] = old_b[i];
         end else if (m_lde && is_w && ti >= 0) begin
            m_sh[ti] = bus_wdata;
         end
         if (ctrl_w) begin
            m_frz = bus_wdata[6];
            m_lde = bus_wdata[7];
         end
      end
   end

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n && cmp_en) begin
         exp_rd = model_read();
         checks++;
         if (bus_rdata !== exp_rd) begin
            errors++;
            $display("FAIL %s: addr=%h actual=%h expected=%h", cur_req, bus_addr, bus_rdata, exp_rd);
         end
      end
   end

   function automatic logic [14:0] rot_addr(input int k);
      case (k % 10)
         0: return A_SEC;  1: return A_MIN;  2: return A_HOUR; 3: return A_DOW;
         4: return A_DATE; 5: return A_MON;  6: return A_YEAR; 7: return A_CENT;
         8: return A_CTRL; default: return 15'h7FF0;
      endcase
   endfunction

   task automatic cyc(input logic s, input logic w, input logic [14:0] a,
                      input logic [7:0] d, input logic tk);
      @(negedge clk); #1;
      bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d; sec_tick = tk;
   endtask
   task automatic idle(input int n, input logic tk);
      for (int i = 0; i < n; i++) begin cyc(1'b1, 1'b0, rot_addr(rot), 8'h00, tk); rot++; end
   endtask
   task automatic wbus(input logic [14:0] a, input logic [7:0] d, input logic tk);
      cyc(1'b1, 1'b1, a, d, tk);
   endtask
   task automatic rd_expect(input logic [14:0] a, input logic [7:0] e, input string req);
      cyc(1'b1, 1'b0, a, 8'h00, 1'b0);
      #3;
      checks++;
      if (bus_rdata !== e) begin
         errors++;
         $display("FAIL %s: addr=%h actual=%h expected=%h", req, a, bus_rdata, e);
      end
   endtask
   task automatic load_time(input logic [7:0] ce, yr, mo, da, dw, hr, mi, se,
                            input logic ctk);
      wbus(A_CTRL, 8'h80, 1'b0);
      wbus(A_CENT, ce, 1'b0); wbus(A_YEAR, yr, 1'b0); wbus(A_MON, mo, 1'b0);
      wbus(A_DATE, da, 1'b0); wbus(A_DOW, dw, 1'b0); wbus(A_HOUR, hr, 1'b0);
      wbus(A_MIN, mi, 1'b0); wbus(A_SEC, se, 1'b0);
      wbus(A_CTRL, 8'h00, ctk);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      cmp_en = 1'b1;
      // R1 reset state
      rd_expect(A_CTRL, 8'h00, "R1"); rd_expect(A_SEC, 8'h00, "R1");
      rd_expect(A_MIN, 8'h00, "R1");  rd_expect(A_HOUR, 8'h00, "R1");
      rd_expect(A_DOW, 8'h01, "R1");  rd_expect(A_DATE, 8'h01, "R1");
      rd_expect(A_MON, 8'h01, "R1");  rd_expect(A_YEAR, 8'h00, "R1");
      rd_expect(A_CENT, 8'h20, "R1");
      // R3 divided ticks, R2 live reads across the map
      cur_req = "R3"; idle(30, 1'b1); idle(10, 1'b0);
      cur_req = "R2"; for (int i = 0; i < 60; i++) idle(1, logic'(i % 3 != 0));
      // R8 freeze holds while the count runs on
      cur_req = "R8";
      load_time(8'h20, 8'h24, 8'h06, 8'h15, 8'h03, 8'h12, 8'h34, 8'h56, 1'b0);
      wbus(A_CTRL, 8'h40, 1'b0);
      idle(40, 1'b1);
      rd_expect(A_SEC, 8'h56, "R8");
      wbus(A_CTRL, 8'h00, 1'b0);
      rd_expect(A_SEC, 8'h06, "R8"); rd_expect(A_MIN, 8'h35, "R8");
      // R11 writes with load bit clear are dropped
      cur_req = "R11";
      wbus(A_SEC, 8'h33, 1'b0); rd_expect(A_SEC, 8'h06, "R11");
      // R12 unmapped space and control spare bits
      cur_req = "R12";
      wbus(15'h7FF2, 8'h55, 1'b0); rd_expect(15'h7FF2, 8'h00, "R12");
      rd_expect(15'h0123, 8'h00, "R12");
      wbus(A_CTRL, 8'h3F, 1'b0); rd_expect(A_CTRL, 8'h00, "R12");
      cyc(1'b0, 1'b0, A_DOW, 8'h00, 1'b0); #3; checks++;
      if (bus_rdata !== 8'h00) begin
         errors++; $display("FAIL R12: deselected actual=%h expected=00", bus_rdata);
      end
      // R9 holding bank while the count runs
      cur_req = "R9";
      wbus(A_CTRL, 8'h80, 1'b1); wbus(A_HOUR, 8'h07, 1'b1);
      idle(12, 1'b1);
      rd_expect(A_HOUR, 8'h07, "R9");
      wbus(A_CTRL, 8'h00, 1'b0);
      rd_expect(A_HOUR, 8'h07, "R10");
      // R10 commit colliding with a tick; R5 R7 rollover to a new century
      cur_req = "R10";
      load_time(8'h20, 8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59, 1'b1);
      idle(3, 1'b1);
      rd_expect(A_SEC, 8'h59, "R10");
      idle(1, 1'b1);
      rd_expect(A_SEC, 8'h00, "R4");  rd_expect(A_HOUR, 8'h00, "R4");
      rd_expect(A_DOW, 8'h01, "R5");  rd_expect(A_DATE, 8'h01, "R6");
      rd_expect(A_MON, 8'h01, "R7");  rd_expect(A_YEAR, 8'h00, "R7");
      rd_expect(A_CENT, 8'h21, "R7");
      // R6 month lengths and leap February
      cur_req = "R6";
      load_time(8'h20, 8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59, 1'b0);
      idle(4, 1'b1); rd_expect(A_DATE, 8'h29, "R6"); rd_expect(A_MON, 8'h02, "R6");
      load_time(8'h20, 8'h24, 8'h02, 8'h29, 8'h04, 8'h23, 8'h59, 8'h59, 1'b0);
      idle(4, 1'b1); rd_expect(A_DATE, 8'h01, "R6"); rd_expect(A_MON, 8'h03, "R6");
      load_time(8'h20, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59, 1'b0);
      idle(4, 1'b1); rd_expect(A_DATE, 8'h01, "R6"); rd_expect(A_MON, 8'h03, "R6");
      load_time(8'h20, 8'h23, 8'h04, 8'h30, 8'h07, 8'h23, 8'h59, 8'h59, 1'b0);
      idle(4, 1'b1); rd_expect(A_DATE, 8'h01, "R6"); rd_expect(A_MON, 8'h05, "R6");
      rd_expect(A_DOW, 8'h01, "R5");
      load_time(8'h20, 8'h23, 8'h01, 8'h31, 8'h02, 8'h23, 8'h59, 8'h59, 1'b0);
      idle(4, 1'b1); rd_expect(A_DATE, 8'h01, "R6"); rd_expect(A_MON, 8'h02, "R6");
      // R7 century wrap
      cur_req = "R7";
      load_time(8'h99, 8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59, 1'b0);
      idle(4, 1'b1); rd_expect(A_CENT, 8'h00, "R7"); rd_expect(A_YEAR, 8'h00, "R7");
      // R4 tens-digit carry in hours
      cur_req = "R4";
      load_time(8'h20, 8'h10, 8'h05, 8'h05, 8'h02, 8'h09, 8'h59, 8'h59, 1'b0);
      idle(4, 1'b1); rd_expect(A_HOUR, 8'h10, "R4"); rd_expect(A_MIN, 8'h00, "R4");
      // freeze and load together, commit under freeze
      cur_req = "R10";
      wbus(A_CTRL, 8'hC0, 1'b1); wbus(A_MIN, 8'h45, 1'b1); idle(6, 1'b1);
      wbus(A_CTRL, 8'h40, 1'b1); idle(8, 1'b1);
      wbus(A_CTRL, 8'h00, 1'b1);
      cur_req = "R2"; idle(200, 1'b1);
      cmp_en = 1'b0;
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule